// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes an asynchronous serial line that carries 8N1 characters and rebuilds 32-bit words from them. A word travels as a short packet: a header character, four payload bytes with the most significant byte first, and a trailer character. The block has three parts. A bit-level receiver detects the start edge, samples each bit in the middle of its period and checks the stop bit. A packet parser shifts payload bytes into an accumulator. A history filter releases a word only when it agrees with the words that came before it.

The filter exists because single words can be damaged on the line. The output register and its one-cycle strobe change only when the last three accepted words are identical. A sender that repeats its value at a slow rate therefore gets through, and a lone corrupted packet is held back. Packets may be separated by long idle gaps, about 100 ms at the default rate, and the receiver waits in idle for as long as needed.

The default timing gives 9600 bit/s from a 50 MHz clock, which is 5208 clocks per bit. This is a parameter.

Top module: `framed_word_rx`

## Requirements
- R1: `rx_serial` passes through two flip-flops before any edge detection. After reset the line is treated as idle (high), `word_out` is zero and `word_strobe` is low.
- R2: A character is a low start bit, 8 data bits least significant bit first, and a high stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled at mid-bit, timed from the falling start edge.
- R3: If the line is high again at the middle of the start bit, the low pulse is a glitch. No character is produced and the receiver returns to idle.
- R4: A character whose stop bit samples low is discarded. It also ends any packet in progress, and the parser ignores characters until the next header.
- R5: A packet is 0x74, then four payload bytes, then 0x78. The word is the payload bytes concatenated with the first byte in bits 31:24. Payload bytes are never 0x74 or 0x78.
- R6: A packet with fewer or more than four payload bytes between header and trailer yields no word.
- R7: A header that arrives inside a packet discards the partial word and starts a new packet.
- R8: On each accepted word, `word_out` takes that word and `word_strobe` pulses for one cycle, but only if the two previously accepted words equal it. Otherwise both outputs hold.
- R9: An idle high line of any length between packets has no effect on later reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| word_out | output | 32 | Last word released by the history filter |
| word_strobe | output | 1 | One-cycle pulse when `word_out` is updated |

## Verification
The assertions check four things on every cycle. The stop-bit verdict is exclusive. A word is only produced right after a trailer character. The output holds between strobes. Every strobe carries the word the parser produced one cycle earlier and lasts a single cycle. The bench scenarios cover what a single cycle cannot show: the three-in-a-row filtering across packets, rejection of short, long and badly framed packets, restart on a stray header, tolerance of start glitches, and reception after a long idle gap.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam logic [7:0] HDR_CHAR = 8'h74;
  localparam logic [7:0] TRL_CHAR = 8'h78;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic {PK_HUNT, PK_BODY} pk_state_e;
endpackage

// File: rtl/fwr_sync.sv
module fwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // reset to the idle (high) line level
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fwr_char_rx.sv
module fwr_char_rx
  import fwr_pkg::*;
#(
  parameter int CLKS_PER_BIT = 5208,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid,
  output logic                 frame_err
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int BW   = $clog2(DATA_BITS);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  rx_state_e            st;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_idx;
  logic                 rx_d;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      rx_d      <= 1'b1;
      shreg     <= '0;
      data      <= '0;
      valid     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_d      <= rx;
      valid     <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt     <= '0;
          bit_idx <= '0;
          if (rx_d && !rx) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CNT_HALF) begin
            cnt <= '0;
            st  <= rx ? RX_IDLE : RX_DATA;   // high at mid-start: glitch
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            shreg <= {rx, shreg[DATA_BITS-1:1]};
            if (bit_idx == BIT_LAST) st <= RX_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (rx) begin
              valid <= 1'b1;
              data  <= shreg;
            end else begin
              frame_err <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fwr_pkt_parser.sv
module fwr_pkt_parser
  import fwr_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ch_valid,
  input  logic                    ch_err,
  input  logic [7:0]              ch_data,
  output logic                    word_valid,
  output logic [8*WORD_BYTES-1:0] word
);
  localparam int WW = 8 * WORD_BYTES;
  localparam int NW = $clog2(WORD_BYTES + 1);
  localparam logic [NW-1:0] N_FULL = NW'(WORD_BYTES);

  pk_state_e     st;
  logic [NW-1:0] nbytes;
  logic [WW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PK_HUNT;
      nbytes     <= '0;
      acc        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (ch_err) begin
        st <= PK_HUNT;
      end else if (ch_valid) begin
        if (ch_data == HDR_CHAR) begin
          st     <= PK_BODY;
          nbytes <= '0;
          acc    <= '0;
        end else if (st == PK_BODY) begin
          if (ch_data == TRL_CHAR) begin
            st <= PK_HUNT;
            if (nbytes == N_FULL) begin
              word       <= acc;
              word_valid <= 1'b1;
            end
          end else if (nbytes == N_FULL) begin
            st <= PK_HUNT;                      // too many payload bytes
          end else begin
            acc    <= (acc << 8) | WW'(ch_data);
            nbytes <= nbytes + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fwr_hist_filter.sv
module fwr_hist_filter #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_word,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word
);
  localparam int OLD = DEPTH - 1;
  localparam int FW  = $clog2(DEPTH);
  localparam logic [FW-1:0] FILL_MAX = FW'(OLD);

  logic [WIDTH-1:0] hist [OLD];
  logic [FW-1:0]    fill;
  logic             match;

  always_comb begin
    match = (fill == FILL_MAX);
    for (int i = 0; i < OLD; i++) begin
      if (hist[i] != in_word) match = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
      for (int i = 0; i < OLD; i++) hist[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        hist[0] <= in_word;
        for (int i = 1; i < OLD; i++) hist[i] <= hist[i-1];
        if (fill != FILL_MAX) fill <= fill + 1'b1;
        if (match) begin
          out_word  <= in_word;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/framed_word_rx.sv
module framed_word_rx #(
  parameter int CLKS_PER_BIT = 5208,
  parameter int WORD_BYTES   = 4,
  parameter int HIST_DEPTH   = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_serial,
  output logic [8*WORD_BYTES-1:0] word_out,
  output logic                    word_strobe
);
  localparam int WW = 8 * WORD_BYTES;

  logic          rx_s;
  logic          char_valid;
  logic          char_err;
  logic [7:0]    char_data;
  logic          word_valid;
  logic [WW-1:0] word_data;

  fwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_serial), .q(rx_s)
  );

  fwr_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_char (
    .clk(clk), .rst(rst), .rx(rx_s),
    .data(char_data), .valid(char_valid), .frame_err(char_err)
  );

  fwr_pkt_parser #(.WORD_BYTES(WORD_BYTES)) u_parse (
    .clk(clk), .rst(rst),
    .ch_valid(char_valid), .ch_err(char_err), .ch_data(char_data),
    .word_valid(word_valid), .word(word_data)
  );

  fwr_hist_filter #(.WIDTH(WW), .DEPTH(HIST_DEPTH)) u_filt (
    .clk(clk), .rst(rst),
    .in_valid(word_valid), .in_word(word_data),
    .out_valid(word_strobe), .out_word(word_out)
  );
endmodule

// File: rtl/fwr_checks.sv
module fwr_checks #(
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          char_valid,
  input logic          char_err,
  input logic [7:0]    char_data,
  input logic          word_valid,
  input logic [WW-1:0] word_data,
  input logic [WW-1:0] word_out,
  input logic          word_strobe
);
  // stop-bit verdict is either good or bad, never both
  assert_stop_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(char_valid && char_err));

  // a word only follows a received trailer character
  assert_word_after_trailer_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(char_valid) && $past(char_data) == 8'h78));

  // output register holds between strobes
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !word_strobe |-> $stable(word_out));

  // each strobe carries the word the parser produced one cycle earlier
  assert_strobe_source_R8: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> ($past(word_valid) && word_out == $past(word_data)));

  // strobe lasts a single cycle
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> !word_strobe);
endmodule

bind framed_word_rx fwr_checks #(.WW(8 * WORD_BYTES)) u_chk (
  .clk(clk), .rst(rst),
  .char_valid(char_valid), .char_err(char_err), .char_data(char_data),
  .word_valid(word_valid), .word_data(word_data),
  .word_out(word_out), .word_strobe(word_strobe)
);

// File: tb/framed_word_rx_tb.sv
`timescale 1ns/1ps
module framed_word_rx_tb;
  localparam int CPB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx  = 1'b1;
  logic [31:0] word_out;
  logic        word_strobe;

  int checks = 0;
  int fails  = 0;
  int n_strobes = 0;
  int mark = 0;

  logic [31:0] mh [2];
  int          mfill = 0;
  logic [31:0] exp_word = 32'h0;

  always #2.5 clk = ~clk;

  framed_word_rx #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst(rst), .rx_serial(rx),
    .word_out(word_out), .word_strobe(word_strobe)
  );

  always @(negedge clk) if (!rst && word_strobe) n_strobes++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input logic stop_ok = 1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(c[i]);
    send_bit(stop_ok);
    if (!stop_ok) send_bit(1'b1);
  endtask

  task automatic send_payload(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_char(w[8*i +: 8]);
  endtask

  // independent model of the three-in-a-row filter (R8)
  task automatic model_push(input logic [31:0] w, output bit s);
    s = (mfill >= 2) && (mh[0] == w) && (mh[1] == w);
    mh[1] = mh[0];
    mh[0] = w;
    if (mfill < 2) mfill++;
    if (s) exp_word = w;
  endtask

  task automatic settle_and_check(input int exp_s, input string req);
    repeat (3 * CPB) @(negedge clk);
    chk((n_strobes - mark) == exp_s, {req, " strobe count"}, 32'(n_strobes - mark), 32'(exp_s));
    chk(word_out == exp_word, {req, " word"}, word_out, exp_word);
  endtask

  task automatic deliver(input logic [31:0] w, input string req);
    bit s;
    mark = n_strobes;
    send_char(8'h74);
    send_payload(w);
    send_char(8'h78);
    model_push(w, s);
    settle_and_check(s ? 1 : 0, req);
  endtask

  function automatic logic [31:0] clean(input logic [31:0] w);
    logic [31:0] r = w;
    for (int i = 0; i < 4; i++)
      if (r[8*i +: 8] == 8'h74 || r[8*i +: 8] == 8'h78) r[8*i +: 8] = 8'h55;
    return r;
  endfunction

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    logic [31:0] wa, wb, wc;
    logic [31:0] pool [3];
    int idx;
    void'($urandom(32'd2718));
    wa = 32'hA1B2C3D4;
    wb = 32'hA1B2C3D5;
    wc = 32'h0F00FF01;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(word_out == 32'h0, "R1 reset word", word_out, 32'h0);
    chk(word_strobe == 1'b0, "R1 reset strobe", 32'(word_strobe), 32'h0);

    // R2 R5 R8: first two copies held back, third released, fourth released again
    deliver(wa, "R8 first copy");
    deliver(wa, "R8 second copy");
    deliver(wa, "R2 R5 third copy");
    deliver(wa, "R8 fourth copy");

    // R8: a lone corrupted word blocks the following copies until three agree
    deliver(wb, "R8 corrupted word");
    deliver(wa, "R8 after corrupt 1");
    deliver(wa, "R8 after corrupt 2");
    deliver(wa, "R8 after corrupt 3");

    // R6: short packet (three payload bytes)
    mark = n_strobes;
    send_char(8'h74); send_char(8'h01); send_char(8'h02); send_char(8'h03); send_char(8'h78);
    settle_and_check(0, "R6 short packet");
    deliver(wa, "R6 history intact after short");

    // R6: long packet (five payload bytes)
    mark = n_strobes;
    send_char(8'h74); send_payload(32'h11223344); send_char(8'h55); send_char(8'h78);
    settle_and_check(0, "R6 long packet");
    deliver(wa, "R6 history intact after long");

    // R4: bad stop bit inside payload abandons the packet
    mark = n_strobes;
    send_char(8'h74); send_char(8'hC0); send_char(8'hC1, 1'b0);
    send_char(8'hC2); send_char(8'hC3); send_char(8'h78);
    settle_and_check(0, "R4 framing error");
    deliver(wa, "R4 history intact after framing error");

    // R7: header inside a packet restarts assembly
    begin
      bit s;
      mark = n_strobes;
      send_char(8'h74); send_char(8'h99); send_char(8'h98);
      send_char(8'h74); send_payload(wc); send_char(8'h78);
      model_push(wc, s);
      settle_and_check(s ? 1 : 0, "R7 restart");
    end
    deliver(wc, "R7 second copy");
    deliver(wc, "R7 third copy");

    // R3: short low pulse on an idle line is ignored
    mark = n_strobes;
    rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
    settle_and_check(0, "R3 glitch");
    deliver(wc, "R3 reception after glitch");

    // R9: long idle gap
    repeat (3000) @(negedge clk);
    deliver(wc, "R9 after long idle");

    // random runs from a small pool (R5 R8)
    pool[0] = clean($urandom());
    pool[1] = clean($urandom());
    pool[2] = clean(pool[0] ^ 32'h0000_0100);
    idx = 0;
    for (int n = 0; n < 40; n++) begin
      if (($urandom() % 10) >= 7) idx = int'($urandom() % 3);
      deliver(pool[idx], "R5 R8 random");
    end

    finish_up();
  end
endmodule